// File: doc/BRIEF.md
# Hub Downstream Port Power and Strap Controller

This block governs the power switches of a four-port hub and owns one dual-purpose configuration pin. Right after reset the pin is an input: the block holds it there for a strapping window measured in millisecond ticks, then samples it once to decide whether port power is switched per port (individual mode) or for all ports at once (ganged mode). From then on the pin is driven as an output that indicates normal or suspended operation, with a polarity that is the inverse of the strapped value.

Each port has an active-low over-current input that is synchronised and debounced against the millisecond tick before it is latched into a sticky status bit. A latched fault turns off the affected power switch. Software clears the status and must then withdraw and reassert the port's power request before power returns. The self/bus-power strap is synchronised and presented as a status bit.

The sequencer has three states. ST_STRAP (entered at reset) counts ticks with the pin undriven and all switches off; after the last tick of the window it moves to ST_LATCH, which captures the pin value in one cycle and always moves on to ST_RUN, where it stays until the next reset.

Top module: `hub_pwr_strap_ctrl`

## Requirements
- R1: From reset until the 50th millisecond tick has been counted, cfg_pin_oe is 0, strap_done is 0 and every bit of pwr_en_n is 1, whatever pwr_req holds.
- R2: The synchronised pin value present when the window ends is latched into gang_mode (1 = ganged, 0 = individual); later changes on cfg_pin_in do not change gang_mode.
- R3: After the window cfg_pin_oe is 1; in ganged mode cfg_pin_out equals suspend_req (0 normal, 1 suspend), in individual mode it equals the inverse of suspend_req (1 normal, 0 suspend).
- R4: In individual mode, after the window, pwr_en_n[i] is 0 exactly when pwr_req[i] is 1 and port i has no latched or pending fault; ports act independently of one another (bit i of each vector belongs to port i).
- R5: In ganged mode only port 0 is used: pwr_en_n[0] follows pwr_req[0] and the port-0 fault, pwr_en_n[3:1] stay 1, pwr_req[3:1] are ignored and oc_n[3:1] never set a status bit.
- R6: An over-current is latched only after oc_n of a monitored port, passed through two synchroniser flops, has been low across 8 consecutive ms_tick pulses; a low period that ends earlier resets the count.
- R7: A latched over-current sets oc_status of that port and drives its pwr_en_n to 1 (in ganged mode this switches off the single shared enable).
- R8: After a fault, power stays off until oc_clr has cleared the status and pwr_req of that port has gone to 0 and back to 1.
- R9: self_powered shows self_pwr_strap (0 bus-powered, 1 self-powered) after two synchroniser flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cfg_pin_in | input | 1 | Level seen at the configuration pin |
| suspend_req | input | 1 | 1 while the hub is suspended |
| self_pwr_strap | input | 1 | Power-source strap, 1 = self-powered |
| oc_n | input | 4 | Active-low over-current flag per port |
| pwr_req | input | 4 | Per-port power-on request, level |
| oc_clr | input | 4 | Per-port clear of the latched fault status |
| pwr_en_n | output | 4 | Active-low power switch enable per port |
| oc_status | output | 4 | Latched over-current status per port |
| gang_mode | output | 1 | Strapped switching mode, 1 = ganged |
| self_powered | output | 1 | Synchronised power-source strap |
| strap_done | output | 1 | 1 once the sequencer is in ST_RUN |
| cfg_pin_oe | output | 1 | Output enable for the configuration pin |
| cfg_pin_out | output | 1 | Value driven on the configuration pin |

## Verification
A sequencer stuck in or leaving ST_STRAP at the wrong tick shows at once on cfg_pin_oe and on the power enables, so the bench samples both one tick before and a few cycles after the 50th tick. A wrongly latched mode shows as the wrong suspend polarity and as power appearing on ports 1 to 3 in ganged mode. A debounce counter that is off by one or not reset by a short glitch shows as a status bit that appears one tick early or after an interrupted fault; a blocking flag that clears too soon shows as power returning immediately after oc_clr without the request being cycled.

// File: rtl/hps_pkg.sv
package hps_pkg;
    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_LATCH = 2'd1,
        ST_RUN   = 2'd2
    } strap_state_e;
endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hps_oc_filter.sv
module hps_oc_filter #(
    parameter int OC_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic oc_act,
    input  logic ms_tick,
    output logic qualified
);
    localparam int CW = $clog2(OC_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || !oc_act) begin
            cnt <= '0;
        end else if (ms_tick && (cnt != CW'(OC_TICKS))) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign qualified = (cnt == CW'(OC_TICKS));

    // R6
    oc_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qualified |-> ($past(oc_act) && $past(enable)));
endmodule

// File: rtl/hps_port_gate.sv
module hps_port_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic req,
    input  logic trip,
    input  logic clr,
    output logic en,
    output logic oc_stat
);
    logic blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_stat <= 1'b0;
            blocked <= 1'b0;
            en      <= 1'b0;
        end else begin
            if (trip)     oc_stat <= 1'b1;
            else if (clr) oc_stat <= 1'b0;

            if (trip)      blocked <= 1'b1;
            else if (!req) blocked <= 1'b0;

            en <= run && req && !oc_stat && !blocked && !trip;
        end
    end

    // R7
    fault_cuts_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_stat |=> !en);

    // R8
    no_power_without_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(en)) |-> ($past(req) && !$past(oc_stat)));
endmodule

// File: rtl/hub_pwr_strap_ctrl.sv
module hub_pwr_strap_ctrl
    import hps_pkg::*;
#(
    parameter int NPORTS   = 4,
    parameter int STRAP_MS = 50,
    parameter int OC_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              cfg_pin_in,
    input  logic              suspend_req,
    input  logic              self_pwr_strap,
    input  logic [NPORTS-1:0] oc_n,
    input  logic [NPORTS-1:0] pwr_req,
    input  logic [NPORTS-1:0] oc_clr,
    output logic [NPORTS-1:0] pwr_en_n,
    output logic [NPORTS-1:0] oc_status,
    output logic              gang_mode,
    output logic              self_powered,
    output logic              strap_done,
    output logic              cfg_pin_oe,
    output logic              cfg_pin_out
);
    localparam int SCW = $clog2(STRAP_MS + 1);

    strap_state_e      state, state_nx;
    logic [SCW-1:0]    strap_cnt;
    logic              gang_q;
    logic              run;
    logic              pin_s;
    logic [NPORTS-1:0] oc_n_s;
    logic [NPORTS-1:0] monitored;
    logic [NPORTS-1:0] trip;
    logic [NPORTS-1:0] gate_en;

    hps_sync #(.W(1), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(cfg_pin_in), .q(pin_s));

    hps_sync #(.W(1), .RST_VAL(1'b0)) u_self_sync (
        .clk(clk), .rst_n(rst_n), .d(self_pwr_strap), .q(self_powered));

    hps_sync #(.W(NPORTS), .RST_VAL({NPORTS{1'b1}})) u_oc_sync (
        .clk(clk), .rst_n(rst_n), .d(oc_n), .q(oc_n_s));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STRAP: if (ms_tick && (strap_cnt == SCW'(STRAP_MS - 1))) state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_STRAP;
        endcase
    end

    // state register, window counter and strap latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_STRAP;
            strap_cnt <= '0;
            gang_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_STRAP && ms_tick) strap_cnt <= strap_cnt + SCW'(1);
            if (state == ST_LATCH) gang_q <= pin_s;
        end
    end

    // outputs decoded from state
    always_comb begin
        run         = 1'b0;
        cfg_pin_oe  = 1'b0;
        cfg_pin_out = 1'b0;
        unique case (state)
            ST_STRAP, ST_LATCH: begin
                run        = 1'b0;
                cfg_pin_oe = 1'b0;
            end
            ST_RUN: begin
                run         = 1'b1;
                cfg_pin_oe  = 1'b1;
                cfg_pin_out = gang_q ? suspend_req : !suspend_req;
            end
            default: ;
        endcase
    end

    assign strap_done = run;
    assign gang_mode  = gang_q;

    generate
        for (genvar i = 0; i < NPORTS; i++) begin : g_port
            if (i == 0) begin : g_lead
                assign monitored[i] = run;
            end else begin : g_follow
                assign monitored[i] = run && !gang_q;
            end

            hps_oc_filter #(.OC_TICKS(OC_TICKS)) u_filt (
                .clk(clk), .rst_n(rst_n), .enable(monitored[i]),
                .oc_act(!oc_n_s[i]), .ms_tick(ms_tick), .qualified(trip[i]));

            hps_port_gate u_gate (
                .clk(clk), .rst_n(rst_n), .run(monitored[i]), .req(pwr_req[i]),
                .trip(trip[i]), .clr(oc_clr[i]), .en(gate_en[i]),
                .oc_stat(oc_status[i]));

            assign pwr_en_n[i] = !gate_en[i];
        end
    endgenerate

    // R1
    strap_power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_done |-> (pwr_en_n == {NPORTS{1'b1}}));

    // R2
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && $past(strap_done)) |-> $stable(gang_mode));

    // R5
    gang_followers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gang_mode |-> (pwr_en_n[NPORTS-1:1] == {(NPORTS-1){1'b1}}));

    // R3
    pin_driven_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_done) |-> $rose(cfg_pin_oe));
endmodule

// File: tb/tb_hub_pwr_strap_ctrl.sv
module tb_hub_pwr_strap_ctrl;
    typedef enum int {K_EN, K_OC, K_OE, K_PIN, K_GANG, K_SELF, K_DONE} kind_e;
    typedef struct {
        string      tag;
        kind_e      kind;
        logic [3:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       cfg_pin_in = 1'b0;
    logic       suspend_req = 1'b0;
    logic       self_pwr_strap = 1'b0;
    logic [3:0] oc_n = 4'hF;
    logic [3:0] pwr_req = 4'h0;
    logic [3:0] oc_clr = 4'h0;
    logic [3:0] pwr_en_n, oc_status;
    logic       gang_mode, self_powered, strap_done, cfg_pin_oe, cfg_pin_out;

    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 0;
    item_t q[$];
    event smp;

    always #4 clk = ~clk;

    hub_pwr_strap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cfg_pin_in(cfg_pin_in),
        .suspend_req(suspend_req), .self_pwr_strap(self_pwr_strap),
        .oc_n(oc_n), .pwr_req(pwr_req), .oc_clr(oc_clr),
        .pwr_en_n(pwr_en_n), .oc_status(oc_status), .gang_mode(gang_mode),
        .self_powered(self_powered), .strap_done(strap_done),
        .cfg_pin_oe(cfg_pin_oe), .cfg_pin_out(cfg_pin_out));

    function automatic logic [3:0] actual(kind_e k);
        case (k)
            K_EN:    return pwr_en_n;
            K_OC:    return oc_status;
            K_OE:    return {3'b0, cfg_pin_oe};
            K_PIN:   return {3'b0, cfg_pin_out};
            K_GANG:  return {3'b0, gang_mode};
            K_SELF:  return {3'b0, self_powered};
            default: return {3'b0, strap_done};
        endcase
    endfunction

    // monitor: drains the scoreboard whenever the driver signals a sample point
    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                item_t it;
                logic [3:0] a;
                it = q.pop_front();
                a = actual(it.kind);
                n_run++;
                if (a !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b", it.tag, a, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input string tag, input kind_e k, input logic [3:0] e);
        item_t it;
        it.tag = tag; it.kind = k; it.exp = e;
        q.push_back(it);
        -> smp;
        #0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        cfg_pin_in = strap;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // ---------------- individual mode ----------------
        pwr_req = 4'hF;
        self_pwr_strap = 1'b1;
        do_reset(1'b0);
        expect_item("R1 enables off after reset", K_EN, 4'hF);
        expect_item("R1 pin undriven after reset", K_OE, 4'h0);
        expect_item("R1 not done after reset", K_DONE, 4'h0);
        expect_item("R9 self-powered strap", K_SELF, 4'h1);
        tick_n(49);
        expect_item("R1 enables off at tick 49", K_EN, 4'hF);
        expect_item("R1 pin undriven at tick 49", K_OE, 4'h0);
        tick_n(1);
        wait_n(4);
        expect_item("R1 done after tick 50", K_DONE, 4'h1);
        expect_item("R2 strap 0 gives individual", K_GANG, 4'h0);
        expect_item("R3 pin driven", K_OE, 4'h1);
        expect_item("R3 individual normal drives 1", K_PIN, 4'h1);
        expect_item("R4 all ports powered", K_EN, 4'h0);
        cfg_pin_in = 1'b1;
        wait_n(4);
        expect_item("R2 mode frozen after window", K_GANG, 4'h0);
        suspend_req = 1'b1;
        wait_n(1);
        expect_item("R3 individual suspend drives 0", K_PIN, 4'h0);
        suspend_req = 1'b0;
        pwr_req = 4'b1011;
        wait_n(2);
        expect_item("R4 per-port requests", K_EN, 4'b0100);
        pwr_req = 4'hF;
        wait_n(2);
        // debounce: 7 ticks do not latch, 8th does
        oc_n = 4'b1101;
        wait_n(3);
        tick_n(7);
        expect_item("R6 no latch after 7 ticks", K_OC, 4'h0);
        expect_item("R6 power kept after 7 ticks", K_EN, 4'h0);
        tick_n(1);
        wait_n(1);
        expect_item("R7 status set on port 1", K_OC, 4'b0010);
        expect_item("R7 port 1 off, others on", K_EN, 4'b0010);
        oc_n = 4'hF;
        wait_n(3);
        oc_clr = 4'b0010;
        wait_n(1);
        oc_clr = 4'h0;
        wait_n(2);
        expect_item("R8 status cleared", K_OC, 4'h0);
        expect_item("R8 still off before request cycle", K_EN, 4'b0010);
        pwr_req[1] = 1'b0;
        wait_n(2);
        pwr_req[1] = 1'b1;
        wait_n(2);
        expect_item("R8 power back after request cycle", K_EN, 4'h0);
        // interrupted fault does not accumulate
        oc_n[2] = 1'b0;
        wait_n(3);
        tick_n(5);
        oc_n[2] = 1'b1;
        wait_n(3);
        oc_n[2] = 1'b0;
        wait_n(3);
        tick_n(5);
        expect_item("R6 interrupted fault not latched", K_OC, 4'h0);
        expect_item("R6 interrupted fault keeps power", K_EN, 4'h0);
        oc_n = 4'hF;
        wait_n(3);

        // ---------------- ganged mode ----------------
        self_pwr_strap = 1'b0;
        pwr_req = 4'hF;
        do_reset(1'b1);
        expect_item("R1 enables off in gang window", K_EN, 4'hF);
        expect_item("R9 bus-powered strap", K_SELF, 4'h0);
        tick_n(50);
        wait_n(4);
        expect_item("R2 strap 1 gives gang", K_GANG, 4'h1);
        expect_item("R3 gang normal drives 0", K_PIN, 4'h0);
        suspend_req = 1'b1;
        wait_n(1);
        expect_item("R3 gang suspend drives 1", K_PIN, 4'h1);
        suspend_req = 1'b0;
        expect_item("R5 only port 0 enable driven", K_EN, 4'b1110);
        pwr_req = 4'b1110;
        wait_n(2);
        expect_item("R5 requests 3..1 ignored", K_EN, 4'hF);
        pwr_req = 4'hF;
        wait_n(2);
        oc_n[2] = 1'b0;
        wait_n(3);
        tick_n(10);
        expect_item("R5 port 2 fault ignored", K_OC, 4'h0);
        expect_item("R5 power kept on port 2 fault", K_EN, 4'b1110);
        oc_n = 4'hF;
        oc_n[0] = 1'b0;
        wait_n(3);
        tick_n(8);
        wait_n(1);
        expect_item("R7 gang fault status", K_OC, 4'b0001);
        expect_item("R7 gang fault cuts shared enable", K_EN, 4'hF);
        oc_n = 4'hF;

        #1;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule